// File: doc/BRIEF.md
# EEPROM Page Write and Busy-Poll Sequencer

This block is the master-side controller for writing into a two-wire serial EEPROM. A client hands it one request: a 10-bit byte address, a byte count and a stream of data bytes. The sequencer builds the whole write frame as a series of commands to a separate bit-level bus engine (START, byte, STOP). That engine owns the SCL/SDA timing and returns the target's acknowledge bit for each byte. The bench can stand in for the engine.

After the STOP that begins the memory's internal programming cycle, the sequencer does not wait a fixed time. It probes the device again and again with a START followed by the write-mode control byte. A NACK means the device is still programming. An ACK means it is ready, so the sequencer closes the bus with a STOP and reports completion. A request that would run over the end of a 16-byte page is refused before any bus activity. A refused byte, or a poll count that reaches a programmable limit, ends the job with an error flag.

Top module: `eeprom_wr_seq`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A `req_valid` seen while busy is ignored and does not change the bus command sequence of the job in progress. After `fin`, the sequencer returns to idle.
- R2: Every byte command that directly follows a START command is the control byte {1,0,1,0, `strap_a2`, address bit 9, address bit 8, 0}. Bit 7 is sent first on the wire, and the last bit is the write-direction bit.
- R3: In the write frame, the byte after the control byte is address bits 7:0. It is followed by exactly `req_len` data bytes in stream order. `dat_take` pulses once per data byte, in the same cycle as that byte's command.
- R4: A request with `req_len` = 0, or with (address bits 3:0) + `req_len` > 16, causes no bus command. One cycle after acceptance, `fin` is high together with `err_page`.
- R5: When the last data byte is acknowledged, the sequencer issues STOP. It then immediately issues START and a control byte to begin polling.
- R6: A NACK on a poll control byte leads to another START and control byte. An ACK leads to one STOP and then `fin` with no error flag set.
- R7: A NACK on the control, address or any data byte of the write frame ends the job: one STOP, no further `dat_take`, then `fin` with `err_nack`.
- R8: Let N be `poll_limit`, or 1 when `poll_limit` is 0. When the Nth poll in a row is NACKed, the sequencer issues STOP and then `fin` with `err_tmo`. An ACK on the Nth poll is a success.
- R9: `eng_go` is never high while an earlier command has not yet received `eng_done`, and never on two cycles in a row.
- R10: After reset, `req_ready` is 1 and `busy`, `fin`, `eng_go`, `dat_take` and all error flags are 0. Op codes on `eng_op` are 0 for START, 1 for byte and 2 for STOP.
- R11: At most one error flag is high at a time. The flags seen with `fin` hold until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 10 | Start byte address |
| req_len | input | 5 | Number of data bytes, 1 to 16 |
| strap_a2 | input | 1 | Device select strap value placed in the control byte |
| poll_limit | input | 16 | Maximum number of completion polls (0 acts as 1) |
| dat_in | input | 8 | Head of the data byte stream |
| dat_take | output | 1 | Head byte consumed |
| eng_go | output | 1 | Issue command to bus engine |
| eng_op | output | 2 | Command: 0 START, 1 byte, 2 STOP |
| eng_byte | output | 8 | Byte to shift out for a byte command |
| eng_done | input | 1 | Engine finished the pending command |
| eng_ack | input | 1 | Target acknowledged the byte (valid with `eng_done`) |
| busy | output | 1 | Job in progress |
| fin | output | 1 | One-cycle job completion pulse |
| err_page | output | 1 | Request refused: empty or crosses a page |
| err_nack | output | 1 | Write frame byte not acknowledged |
| err_tmo | output | 1 | Poll limit reached without acknowledge |

## Verification
The poll that reaches the limit and the target becoming ready can both land on the same acknowledge slot. The success path and the timeout path then compete in one cycle. The bench sets the target's busy-poll count to exactly `poll_limit` − 1 and separately to exactly `poll_limit`. It expects a clean finish in the first case and `err_tmo` in the second, each with the full predicted command list. A second overlap is a new `req_valid` raised while a job runs. The bench judges it by comparing the running job's command sequence against the prediction and seeing that no extra job follows.

// File: rtl/ewseq_pkg.sv
`timescale 1ns/1ps
package ewseq_pkg;
  localparam int            EW_ADDR_W   = 10;
  localparam logic [3:0]    EW_CTRL_TAG = 4'b1010;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } ew_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_START,
    ST_W_CTRL,
    ST_W_ADDR,
    ST_W_DATA,
    ST_W_STOP,
    ST_P_START,
    ST_P_CTRL,
    ST_P_STOP,
    ST_ABORT,
    ST_FIN
  } ew_state_e;

  typedef enum logic [1:0] {
    RES_OK,
    RES_PAGE,
    RES_NACK,
    RES_TMO
  } ew_res_e;
endpackage

// File: rtl/ewseq_rsync.sv
`timescale 1ns/1ps
module ewseq_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ewseq_range.sv
`timescale 1ns/1ps
module ewseq_range #(
  parameter  int PAGE_BYTES = 16,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W      = OFF_W + 1
) (
  input  logic [OFF_W-1:0] addr_off,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  logic [LEN_W:0] end_pos;

  always_comb begin
    end_pos = {{(LEN_W+1-OFF_W){1'b0}}, addr_off} + {1'b0, len};
    ok      = (len != '0) && (end_pos <= (LEN_W+1)'(PAGE_BYTES));
  end
endmodule

// File: rtl/ewseq_ctr.sv
`timescale 1ns/1ps
module ewseq_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | inc;
    q_d  = clr ? '0 : q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/ewseq_fsm.sv
`timescale 1ns/1ps
module ewseq_fsm
  import ewseq_pkg::*;
#(
  parameter int LEN_W  = 5,
  parameter int POLL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 range_ok,
  input  logic [EW_ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 strap_a2,
  input  logic [POLL_W-1:0]    poll_limit,
  input  logic [7:0]           dat_in,
  input  logic                 eng_done,
  input  logic                 eng_ack,
  input  logic [LEN_W-1:0]     byte_cnt,
  input  logic [POLL_W-1:0]    poll_cnt,
  output logic                 req_ready,
  output logic                 busy,
  output logic                 fin,
  output logic                 eng_go,
  output logic [1:0]           eng_op,
  output logic [7:0]           eng_byte,
  output logic                 dat_take,
  output logic                 cnt_clr,
  output logic                 byte_inc,
  output logic                 poll_inc,
  output logic                 err_page,
  output logic                 err_nack,
  output logic                 err_tmo
);
  ew_state_e            st_q, st_d;
  ew_res_e              res_q, res_d;
  logic                 pend_q, pend_d;
  logic [EW_ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]     len_q;
  logic                 a2_q;
  logic                 lat_en;
  logic                 op_state, step;
  logic                 last_byte, last_poll;
  logic [POLL_W:0]      poll_next;
  logic [7:0]           ctrl_byte;

  // command decode
  always_comb begin
    ctrl_byte = {EW_CTRL_TAG, a2_q, addr_q[9:8], 1'b0};
    op_state  = (st_q != ST_IDLE) && (st_q != ST_FIN);
    eng_go    = op_state && !pend_q;
    step      = pend_q && eng_done;
    eng_op    = OP_STOP;
    eng_byte  = 8'h00;
    case (st_q)
      ST_W_START, ST_P_START: eng_op = OP_START;
      ST_W_CTRL, ST_P_CTRL: begin
        eng_op   = OP_BYTE;
        eng_byte = ctrl_byte;
      end
      ST_W_ADDR: begin
        eng_op   = OP_BYTE;
        eng_byte = addr_q[7:0];
      end
      ST_W_DATA: begin
        eng_op   = OP_BYTE;
        eng_byte = dat_in;
      end
      default: eng_op = OP_STOP;
    endcase
    dat_take  = eng_go && (st_q == ST_W_DATA);
    last_byte = (byte_cnt == len_q - LEN_W'(1));
    poll_next = {1'b0, poll_cnt} + (POLL_W+1)'(1);
    last_poll = (poll_next >= {1'b0, poll_limit});
  end

  // next state
  always_comb begin
    st_d     = st_q;
    res_d    = res_q;
    lat_en   = 1'b0;
    byte_inc = 1'b0;
    poll_inc = 1'b0;
    pend_d   = pend_q;
    if (eng_go)    pend_d = 1'b1;
    else if (step) pend_d = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        lat_en = 1'b1;
        if (range_ok) begin
          st_d  = ST_W_START;
          res_d = RES_OK;
        end else begin
          st_d  = ST_FIN;
          res_d = RES_PAGE;
        end
      end
      ST_W_START: if (step) st_d = ST_W_CTRL;
      ST_W_CTRL: if (step) begin
        if (eng_ack) st_d = ST_W_ADDR;
        else begin st_d = ST_ABORT; res_d = RES_NACK; end
      end
      ST_W_ADDR: if (step) begin
        if (eng_ack) st_d = ST_W_DATA;
        else begin st_d = ST_ABORT; res_d = RES_NACK; end
      end
      ST_W_DATA: if (step) begin
        if (!eng_ack) begin
          st_d  = ST_ABORT;
          res_d = RES_NACK;
        end else begin
          byte_inc = 1'b1;
          if (last_byte) st_d = ST_W_STOP;
        end
      end
      ST_W_STOP:  if (step) st_d = ST_P_START;
      ST_P_START: if (step) st_d = ST_P_CTRL;
      ST_P_CTRL: if (step) begin
        if (eng_ack) st_d = ST_P_STOP;
        else begin
          poll_inc = 1'b1;
          if (last_poll) begin st_d = ST_ABORT; res_d = RES_TMO; end
          else           st_d = ST_P_START;
        end
      end
      ST_P_STOP, ST_ABORT: if (step) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = lat_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_OK;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      a2_q   <= 1'b0;
    end else if (lat_en) begin
      addr_q <= req_addr;
      len_q  <= req_len;
      a2_q   <= strap_a2;
    end
  end

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    busy      = !req_ready;
    fin       = (st_q == ST_FIN);
    err_page  = (res_q == RES_PAGE);
    err_nack  = (res_q == RES_NACK);
    err_tmo   = (res_q == RES_TMO);
  end
endmodule

// File: rtl/eeprom_wr_seq.sv
`timescale 1ns/1ps
module eeprom_wr_seq #(
  parameter  int PAGE_BYTES = 16,
  parameter  int POLL_W     = 16,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W      = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [9:0]        req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              strap_a2,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [7:0]        dat_in,
  output logic              dat_take,
  output logic              eng_go,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_byte,
  input  logic              eng_done,
  input  logic              eng_ack,
  output logic              busy,
  output logic              fin,
  output logic              err_page,
  output logic              err_nack,
  output logic              err_tmo
);
  logic              rst_sync_n;
  logic              range_ok;
  logic              cnt_clr, byte_inc, poll_inc;
  logic [LEN_W-1:0]  byte_cnt;
  logic [POLL_W-1:0] poll_cnt;

  ewseq_rsync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ewseq_range #(.PAGE_BYTES(PAGE_BYTES)) u_range (
    .addr_off (req_addr[OFF_W-1:0]),
    .len      (req_len),
    .ok       (range_ok)
  );

  ewseq_ctr #(.W(LEN_W)) u_byte_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .inc   (byte_inc),
    .q     (byte_cnt)
  );

  ewseq_ctr #(.W(POLL_W)) u_poll_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .inc   (poll_inc),
    .q     (poll_cnt)
  );

  ewseq_fsm #(.LEN_W(LEN_W), .POLL_W(POLL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .range_ok   (range_ok),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .strap_a2   (strap_a2),
    .poll_limit (poll_limit),
    .dat_in     (dat_in),
    .eng_done   (eng_done),
    .eng_ack    (eng_ack),
    .byte_cnt   (byte_cnt),
    .poll_cnt   (poll_cnt),
    .req_ready  (req_ready),
    .busy       (busy),
    .fin        (fin),
    .eng_go     (eng_go),
    .eng_op     (eng_op),
    .eng_byte   (eng_byte),
    .dat_take   (dat_take),
    .cnt_clr    (cnt_clr),
    .byte_inc   (byte_inc),
    .poll_inc   (poll_inc),
    .err_page   (err_page),
    .err_nack   (err_nack),
    .err_tmo    (err_tmo)
  );
endmodule

// File: rtl/ewseq_chk.sv
`timescale 1ns/1ps
module ewseq_chk #(
  parameter  int PAGE_BYTES = 16,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W      = OFF_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic [1:0]       req_hi,
  input logic [LEN_W-1:0] req_len,
  input logic             strap_a2,
  input logic             eng_go,
  input logic [1:0]       eng_op,
  input logic [7:0]       eng_byte,
  input logic             eng_done,
  input logic             dat_take,
  input logic             busy,
  input logic             fin,
  input logic             err_page,
  input logic             err_nack,
  input logic             err_tmo
);
  logic       outstanding, after_start, a2_l;
  logic [1:0] hi_l;
  logic       fits;

  assign fits = (req_len != '0) &&
                (({1'b0, {(LEN_W-OFF_W){1'b0}}, req_off} + {1'b0, req_len}) <= (LEN_W+1)'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      after_start <= 1'b0;
      a2_l        <= 1'b0;
      hi_l        <= 2'b00;
    end else begin
      if (eng_go)        outstanding <= 1'b1;
      else if (eng_done) outstanding <= 1'b0;
      if (eng_go)        after_start <= (eng_op == 2'd0);
      if (req_valid && req_ready) begin
        a2_l <= strap_a2;
        hi_l <= req_hi;
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> !outstanding);                                            // R9
  AST_GO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);                                                 // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !eng_go);                                              // R1
  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> req_ready);                                                  // R1
  AST_FIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (busy && !eng_go));                                          // R1
  AST_CTRL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_go && eng_op == 2'd1 && after_start) |-> (eng_byte == {4'b1010, a2_l, hi_l, 1'b0})); // R2
  AST_TAKE_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_take |-> (eng_go && eng_op == 2'd1 && !after_start));            // R3
  AST_PAGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !fits) |=> (fin && err_page));            // R4
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_page, err_nack, err_tmo}));                            // R11
endmodule

bind eeprom_wr_seq ewseq_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_off   (req_addr[$clog2(PAGE_BYTES)-1:0]),
  .req_hi    (req_addr[9:8]),
  .req_len   (req_len),
  .strap_a2  (strap_a2),
  .eng_go    (eng_go),
  .eng_op    (eng_op),
  .eng_byte  (eng_byte),
  .eng_done  (eng_done),
  .dat_take  (dat_take),
  .busy      (busy),
  .fin       (fin),
  .err_page  (err_page),
  .err_nack  (err_nack),
  .err_tmo   (err_tmo)
);

// File: tb/eeprom_wr_seq_tb.sv
`timescale 1ns/1ps
module eeprom_wr_seq_tb;
  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [9:0]  req_addr;
  logic [4:0]  req_len;
  logic        strap_a2;
  logic [15:0] poll_limit;
  logic [7:0]  dat_in;
  logic        dat_take, eng_go, eng_done, eng_ack;
  logic [1:0]  eng_op;
  logic [7:0]  eng_byte;
  logic        busy, fin, err_page, err_nack, err_tmo;

  eeprom_wr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .strap_a2(strap_a2),
    .poll_limit(poll_limit), .dat_in(dat_in), .dat_take(dat_take),
    .eng_go(eng_go), .eng_op(eng_op), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_ack(eng_ack), .busy(busy), .fin(fin),
    .err_page(err_page), .err_nack(err_nack), .err_tmo(err_tmo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit hung = 0;

  logic [7:0] wdata [16];
  int widx, take_n, overlap;
  assign dat_in = wdata[widx[3:0]];

  // target / engine model state
  int nack_pos, busy_polls, stops_seen, byte_in_frame, polls_seen;
  int log_op [128];
  int log_byte [128];
  int log_n;
  int exp_op [128];
  int exp_byte [128];
  int exp_n, exp_take, exp_res;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // engine responder
  initial begin
    eng_done = 1'b0;
    eng_ack  = 1'b0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (eng_go) begin
        automatic bit a = 1'b1;
        automatic int k = $urandom_range(1, 3);
        if (log_n < 128) begin
          log_op[log_n]   = int'(eng_op);
          log_byte[log_n] = int'(eng_byte);
          log_n++;
        end
        if (dat_take) begin widx++; take_n++; end
        if (eng_op == 2'd0) byte_in_frame = 0;
        else if (eng_op == 2'd2) stops_seen++;
        else begin
          if (stops_seen == 0) a = (byte_in_frame != nack_pos);
          else begin a = (polls_seen >= busy_polls); polls_seen++; end
          byte_in_frame++;
        end
        for (int w = 0; w < k; w++) begin
          @(negedge clk);
          if (eng_go) overlap++;
        end
        eng_done = 1'b1;
        eng_ack  = a;
      end
    end
  end

  task automatic push(input int op, input int b);
    exp_op[exp_n]   = op;
    exp_byte[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input int addr, input int len, input int a2, input int np,
                           input int bp, input int lim);
    automatic int ctrl = 8'hA0 | (a2 << 3) | (((addr >> 8) & 3) << 1);
    automatic int l = (lim == 0) ? 1 : lim;
    exp_n = 0; exp_take = 0;
    if (len == 0 || (addr % 16) + len > 16) begin exp_res = 1; return; end
    push(0, 0); push(1, ctrl);
    if (np == 0) begin push(2, 0); exp_res = 2; return; end
    push(1, addr & 8'hFF);
    if (np == 1) begin push(2, 0); exp_res = 2; return; end
    for (int j = 0; j < len; j++) begin
      push(1, int'(wdata[j])); exp_take++;
      if (np == 2 + j) begin push(2, 0); exp_res = 2; return; end
    end
    push(2, 0);
    for (int p = 0; p < 64; p++) begin
      push(0, 0); push(1, ctrl);
      if (p >= bp)       begin push(2, 0); exp_res = 0; return; end
      if (p + 1 >= l)    begin push(2, 0); exp_res = 3; return; end
    end
  endtask

  task automatic run_txn(input int addr, input int len, input int a2, input int np,
                         input int bp, input int lim, input bit stray, input string tag);
    automatic int first_bad = -1;
    automatic int w;
    automatic logic [2:0] exp_flags, act_flags;
    automatic string rtag;
    if (hung) return;
    for (int i = 0; i < 16; i++) wdata[i] = 8'($urandom);
    build_exp(addr, len, a2, np, bp, lim);
    @(negedge clk);
    widx = 0; take_n = 0; log_n = 0;
    nack_pos = np; busy_polls = bp; stops_seen = 0; byte_in_frame = 0; polls_seen = 0;
    req_addr = 10'(addr); req_len = 5'(len); strap_a2 = a2[0]; poll_limit = 16'(lim);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin
      repeat (3) @(negedge clk);
      req_addr = ~10'(addr); req_len = 5'd1; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    for (w = 0; w < 4000; w++) begin
      if (fin) break;
      @(negedge clk);
    end
    if (w >= 4000) begin
      hung = 1;
      chk(1'b0, {tag, " watchdog"}, 0, 1);
      return;
    end
    exp_flags = (exp_res == 1) ? 3'b001 : (exp_res == 2) ? 3'b010 : (exp_res == 3) ? 3'b100 : 3'b000;
    act_flags = {err_tmo, err_nack, err_page};
    rtag = (exp_res == 1) ? "R4" : (exp_res == 2) ? "R7" : (exp_res == 3) ? "R8" : "R6";
    chk(act_flags == exp_flags, {rtag, " flags ", tag}, int'(act_flags), int'(exp_flags));
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (first_bad < 0 && (log_op[i] != exp_op[i] || log_byte[i] != exp_byte[i])) first_bad = i;
    chk(log_n == exp_n && first_bad < 0, {"R2 R3 R5 ", rtag, " sequence ", tag},
        (first_bad < 0) ? log_n : log_byte[first_bad], (first_bad < 0) ? exp_n : exp_byte[first_bad]);
    chk(take_n == exp_take, {"R3 take count ", tag}, take_n, exp_take);
    @(negedge clk);
    act_flags = {err_tmo, err_nack, err_page};
    chk(act_flags == exp_flags && req_ready, {"R11 flags held ", tag}, int'(act_flags), int'(exp_flags));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
    strap_a2 = 1'b0; poll_limit = '0;
    widx = 0; take_n = 0; overlap = 0; log_n = 0;
    nack_pos = 99; busy_polls = 0; stops_seen = 0; byte_in_frame = 0; polls_seen = 0;
    for (int i = 0; i < 16; i++) wdata[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !busy && !fin && !eng_go && !dat_take && !err_page && !err_nack && !err_tmo,
        "R10 reset state", int'({req_ready, busy, fin, eng_go}), 8);

    run_txn(10'h155, 1, 1, 99, 2, 8, 1'b1, "R1 single byte with stray request");
    run_txn(10'h3F0, 16, 0, 99, 0, 8, 1'b0, "full page first poll ready");
    run_txn(10'h00E, 3, 0, 99, 0, 8, 1'b0, "R4 crosses page");
    run_txn(10'h020, 0, 1, 99, 0, 8, 1'b0, "R4 zero length");
    run_txn(10'h000, 17, 1, 99, 0, 8, 1'b0, "R4 length 17");
    run_txn(10'h0F8, 8, 1, 99, 0, 8, 1'b0, "R4 exact page end");
    run_txn(10'h2A3, 4, 1, 0, 0, 8, 1'b0, "R7 control nack");
    run_txn(10'h2A3, 4, 0, 1, 0, 8, 1'b0, "R7 address nack");
    run_txn(10'h1C4, 6, 1, 5, 0, 8, 1'b0, "R7 data nack");
    run_txn(10'h101, 2, 0, 99, 3, 4, 1'b0, "R8 ready on last allowed poll");
    run_txn(10'h101, 2, 0, 99, 4, 4, 1'b0, "R8 limit reached");
    run_txn(10'h307, 1, 1, 99, 5, 0, 1'b0, "R8 zero limit");
    run_txn(10'h23F, 1, 0, 99, 1, 3, 1'b0, "R5 last byte of page");

    for (int t = 0; t < 40; t++) begin
      automatic int a   = $urandom_range(0, 1023);
      automatic int off = a % 16;
      automatic int l   = ($urandom_range(0, 9) < 8) ? $urandom_range(1, 16 - off) : $urandom_range(0, 20);
      automatic int np  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, l + 1) : 99;
      run_txn(a, l, $urandom_range(0, 1), np, $urandom_range(0, 5), $urandom_range(0, 6),
              1'b0, "random");
    end

    chk(overlap == 0, "R9 command overlap", overlap, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 global watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule